// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Sequencer

This block sits on the host side of a parallel NOR flash bus. A client hands it one request at a time on a valid/ready port: program a word, program a word in unlock-bypass mode, leave unlock-bypass mode, or erase a sector. The block turns each request into the unlock and command write cycles the flash expects. Every strobe edge is placed by parameterised clock counts. The data and address lines are split into separate in and out buses, with an output-enable for the data driver.

After a program or the final sector of an erase, the block polls the flash with pairs of status reads and applies the toggle-bit algorithm. If bit 6 is still toggling once the timeout flag (bit 5) is set, the block reads a further pair to recheck. It then reads the target location back to verify it. A response pulse carries a two-bit result code. Several sectors can be queued into one erase. Each added sector is bracketed by a check of status bit 3, which reports whether the flash's sector-acceptance window has already closed.

The control state machine has these states: `S_IDLE` (accept), `S_CMD` (write cycles), `S_PRE3` and `S_POST3` (bit-3 checks around an added sector), `S_POLL1`/`S_POLL2` (toggle pair), `S_RCHK1`/`S_RCHK2` (recheck pair), `S_RESET` (abort write), `S_VERIFY` (read-back) and `S_RESP` (one-cycle response).

The transitions are:
- IDLE→CMD on a new request, or IDLE→PRE3 when an erase adds a sector.
- CMD→POLL1, CMD→POST3 or CMD→RESP after the last write.
- PRE3→CMD or PRE3→RESP.
- POST3→POLL1 or POST3→RESP.
- POLL1→POLL2.
- POLL2→VERIFY when bit 6 is steady.
- POLL2→POLL1 when bit 6 toggles and bit 5 is clear.
- POLL2→RCHK1 when bit 6 toggles and bit 5 is set.
- RCHK1→RCHK2.
- RCHK2→VERIFY or RCHK2→RESET.
- RESET→RESP.
- VERIFY→RESP.
- RESP→IDLE.

Top module: `flash_seq`

## Requirements
- R1: An ordinary program request (op 0) writes AAh at 555h, 55h at 2AAh, A0h at 555h, then the data at the request address, and then polls.
- R2: A bypass program request (op 1) made outside bypass mode first writes AAh@555h, 55h@2AAh and 20h@555h. Every bypass program then writes A0h at address 0 followed by data at the address. Requests made while the block is already in bypass mode skip the three entry writes.
- R3: A bypass exit request (op 2) writes 90h then 00h, both at address 0. It responds with OK and leaves bypass mode, so the next op 1 repeats the entry writes.
- R4: An erase request (op 3) made with no erase open writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h at the sector address. With `req_more`=1 it responds OK at once and leaves the erase open. With `req_more`=0 it polls.
- R5: An erase request made while an erase is open reads status before writing only 30h at the sector address, and reads status again after that write. A status bit 3 of 1 on either read ends the request with code 3 (late) and closes the erase. If both reads show 0, the request finishes as in R4.
- R6: On every write cycle, chip enable is low for exactly T_SETUP cycles before write enable falls. Write enable stays low for exactly T_PULSE cycles and chip enable stays low for T_HOLD cycles after it rises. Address and data are stable throughout, output enable stays high, and the data driver is enabled.
- R7: On every read cycle, output enable is low for exactly T_RACC cycles, write enable is high and the data driver is off.
- R8: If bit 6 is equal in both reads of a status pair, the operation is complete and the block proceeds to verify.
- R9: If bit 6 differs within a pair and bit 5 of the second read is 0, the block reads another pair.
- R10: If bit 6 differs and bit 5 is 1, the block reads one more pair. If bit 6 is equal in that pair, the operation is complete.
- R11: If bit 6 still differs in the recheck pair, the block writes F0h at address 0, responds with code 1 (timeout), and leaves bypass and erase modes.
- R12: After completion the block reads the target address. The result is code 0 if the read-back equals the written data (all ones for an erase), and code 2 (verify) otherwise.
- R13: `req_ready` is high only when the block is idle. Each accepted request yields exactly one `rsp_valid` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_op | input | 2 | 0 program, 1 bypass program, 2 bypass exit, 3 sector erase |
| req_addr | input | AW | Word or sector address |
| req_data | input | DW | Data to program |
| req_more | input | 1 | Erase: further sectors follow |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_code | output | 2 | 0 OK, 1 timeout, 2 verify, 3 late |
| f_addr | output | AW | Flash address |
| f_dq_o | output | DW | Flash write data |
| f_dq_oe | output | 1 | Drive enable for write data |
| f_ce_n | output | 1 | Chip enable, active low |
| f_we_n | output | 1 | Write enable, active low |
| f_oe_n | output | 1 | Output enable, active low |
| f_dq_i | input | DW | Flash read data |

## Verification
A state machine stuck in or skipping a state shows within one bus cycle. The bench sees either a write it never queued, or a missing write when the response arrives. A polling decision taken on the wrong bit changes how many status reads the flash model receives before the verify read. That in turn changes the result code at the next response. Lost bypass or erase-open state shows at the very next request, as entry writes appear or vanish.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
    typedef enum logic [1:0] {
        OP_PROG   = 2'd0,
        OP_BPROG  = 2'd1,
        OP_BEXIT  = 2'd2,
        OP_ERASE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_TIMEOUT = 2'd1,
        RES_VERIFY  = 2'd2,
        RES_LATE    = 2'd3
    } res_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SET,
        PH_PULSE,
        PH_HOLD,
        PH_READ
    } phase_e;
endpackage

// File: rtl/fbus_cycle.sv
module fbus_cycle
    import flash_seq_pkg::*;
#(
    parameter int AW      = 20,
    parameter int DW      = 16,
    parameter int T_SETUP = 2,
    parameter int T_PULSE = 3,
    parameter int T_HOLD  = 1,
    parameter int T_RACC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] f_addr,
    output logic [DW-1:0] f_dq_o,
    output logic          f_dq_oe,
    output logic          f_ce_n,
    output logic          f_we_n,
    output logic          f_oe_n,
    input  logic [DW-1:0] f_dq_i
);
    localparam int TMAX = (T_SETUP > T_PULSE ? T_SETUP : T_PULSE) > (T_HOLD > T_RACC ? T_HOLD : T_RACC)
                        ? (T_SETUP > T_PULSE ? T_SETUP : T_PULSE) : (T_HOLD > T_RACC ? T_HOLD : T_RACC);
    localparam int CW = $clog2(TMAX + 1) + 1;

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] a_q;
    logic [DW-1:0] d_q;
    logic          done_q;
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            a_q     <= '0;
            d_q     <= '0;
            done_q  <= 1'b0;
            rd_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: if (start) begin
                    a_q     <= addr;
                    d_q     <= wdata;
                    cnt_q   <= '0;
                    phase_q <= rd ? PH_READ : PH_SET;
                end
                PH_SET: if (cnt_q == CW'(T_SETUP - 1)) begin
                    cnt_q <= '0; phase_q <= PH_PULSE;
                end else cnt_q <= cnt_q + 1'b1;
                PH_PULSE: if (cnt_q == CW'(T_PULSE - 1)) begin
                    cnt_q <= '0; phase_q <= PH_HOLD;
                end else cnt_q <= cnt_q + 1'b1;
                PH_HOLD: if (cnt_q == CW'(T_HOLD - 1)) begin
                    phase_q <= PH_IDLE; done_q <= 1'b1;
                end else cnt_q <= cnt_q + 1'b1;
                PH_READ: if (cnt_q == CW'(T_RACC - 1)) begin
                    rd_q <= f_dq_i; phase_q <= PH_IDLE; done_q <= 1'b1;
                end else cnt_q <= cnt_q + 1'b1;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        f_addr  = a_q;
        f_dq_o  = d_q;
        f_ce_n  = (phase_q == PH_IDLE);
        f_we_n  = (phase_q != PH_PULSE);
        f_oe_n  = (phase_q != PH_READ);
        f_dq_oe = (phase_q == PH_SET) || (phase_q == PH_PULSE) || (phase_q == PH_HOLD);
        done    = done_q;
        rdata   = rd_q;
    end

    // R6
    we_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !f_we_n |-> (!f_ce_n && f_oe_n && f_dq_oe));
    // R6
    we_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!f_we_n && !$past(f_we_n)) |-> ($stable(f_addr) && $stable(f_dq_o)));
    // R7
    read_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !f_oe_n |-> (f_we_n && !f_dq_oe && !f_ce_n));
    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int AW      = 20,
    parameter int DW      = 16,
    parameter int T_SETUP = 2,
    parameter int T_PULSE = 3,
    parameter int T_HOLD  = 1,
    parameter int T_RACC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          req_more,
    output logic          rsp_valid,
    output logic [1:0]    rsp_code,
    output logic [AW-1:0] f_addr,
    output logic [DW-1:0] f_dq_o,
    output logic          f_dq_oe,
    output logic          f_ce_n,
    output logic          f_we_n,
    output logic          f_oe_n,
    input  logic [DW-1:0] f_dq_i
);
    localparam logic [AW-1:0] A_U1 = AW'(12'h555);
    localparam logic [AW-1:0] A_U2 = AW'(12'h2AA);

    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_PRE3, S_POST3, S_POLL1, S_POLL2,
        S_RCHK1, S_RCHK2, S_RESET, S_VERIFY, S_RESP
    } state_e;

    state_e        state_q;
    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          more_q, add_q, issued_q, bypass_q, eopen_q;
    logic [2:0]    step_q, last_step;
    logic [DW-1:0] r1_q;
    res_e          code_q;
    logic [AW-1:0] cmd_a, eng_addr;
    logic [DW-1:0] cmd_d, eng_wdata, eng_rdata, expect_d;
    logic          eng_start, eng_rd, eng_done;
    op_e           req_op_e;

    assign req_op_e = op_e'(req_op);
    assign expect_d = (op_q == OP_ERASE) ? {DW{1'b1}} : data_q;

    // command table: (operation, step) -> address and data of the write
    always_comb begin
        cmd_a = '0;
        cmd_d = '0;
        last_step = 3'd0;
        unique case (op_q)
            OP_PROG: begin
                last_step = 3'd3;
                case (step_q)
                    3'd0:    begin cmd_a = A_U1; cmd_d = DW'(8'hAA); end
                    3'd1:    begin cmd_a = A_U2; cmd_d = DW'(8'h55); end
                    3'd2:    begin cmd_a = A_U1; cmd_d = DW'(8'hA0); end
                    default: begin cmd_a = addr_q; cmd_d = data_q; end
                endcase
            end
            OP_BPROG: begin
                last_step = 3'd4;
                case (step_q)
                    3'd0:    begin cmd_a = A_U1; cmd_d = DW'(8'hAA); end
                    3'd1:    begin cmd_a = A_U2; cmd_d = DW'(8'h55); end
                    3'd2:    begin cmd_a = A_U1; cmd_d = DW'(8'h20); end
                    3'd3:    begin cmd_a = '0;   cmd_d = DW'(8'hA0); end
                    default: begin cmd_a = addr_q; cmd_d = data_q; end
                endcase
            end
            OP_BEXIT: begin
                last_step = 3'd1;
                cmd_d = (step_q == 3'd0) ? DW'(8'h90) : '0;
            end
            OP_ERASE: begin
                last_step = 3'd5;
                case (step_q)
                    3'd0, 3'd3: begin cmd_a = A_U1; cmd_d = DW'(8'hAA); end
                    3'd1, 3'd4: begin cmd_a = A_U2; cmd_d = DW'(8'h55); end
                    3'd2:       begin cmd_a = A_U1; cmd_d = DW'(8'h80); end
                    default:    begin cmd_a = addr_q; cmd_d = DW'(8'h30); end
                endcase
            end
            default: ;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        req_ready = (state_q == S_IDLE);
        rsp_valid = (state_q == S_RESP);
        rsp_code  = code_q;
        eng_start = 1'b0;
        eng_rd    = 1'b1;
        eng_addr  = addr_q;
        eng_wdata = '0;
        unique case (state_q)
            S_IDLE, S_RESP: ;
            S_CMD: begin
                eng_start = !issued_q; eng_rd = 1'b0;
                eng_addr = cmd_a; eng_wdata = cmd_d;
            end
            S_RESET: begin
                eng_start = !issued_q; eng_rd = 1'b0;
                eng_addr = '0; eng_wdata = DW'(8'hF0);
            end
            default: eng_start = !issued_q;
        endcase
    end

    // state register and request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            op_q     <= OP_PROG;
            addr_q   <= '0;
            data_q   <= '0;
            more_q   <= 1'b0;
            add_q    <= 1'b0;
            issued_q <= 1'b0;
            bypass_q <= 1'b0;
            eopen_q  <= 1'b0;
            step_q   <= '0;
            r1_q     <= '0;
            code_q   <= RES_OK;
        end else begin
            if (eng_start) issued_q <= 1'b1;
            if (eng_done)  issued_q <= 1'b0;
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    op_q   <= req_op_e;
                    addr_q <= req_addr;
                    data_q <= req_data;
                    more_q <= req_more;
                    add_q  <= (req_op_e == OP_ERASE) && eopen_q;
                    code_q <= RES_OK;
                    if (req_op_e != OP_ERASE) eopen_q <= 1'b0;
                    if (req_op_e == OP_BPROG) bypass_q <= 1'b1;
                    if (req_op_e == OP_BPROG && bypass_q)      step_q <= 3'd3;
                    else if (req_op_e == OP_ERASE && eopen_q)  step_q <= 3'd5;
                    else                                       step_q <= 3'd0;
                    state_q <= ((req_op_e == OP_ERASE) && eopen_q) ? S_PRE3 : S_CMD;
                end
                S_CMD: if (eng_done) begin
                    if (step_q != last_step) step_q <= step_q + 3'd1;
                    else begin
                        unique case (op_q)
                            OP_PROG, OP_BPROG: state_q <= S_POLL1;
                            OP_BEXIT: begin bypass_q <= 1'b0; state_q <= S_RESP; end
                            OP_ERASE: begin
                                if (add_q) state_q <= S_POST3;
                                else if (more_q) begin eopen_q <= 1'b1; state_q <= S_RESP; end
                                else state_q <= S_POLL1;
                            end
                            default: state_q <= S_RESP;
                        endcase
                    end
                end
                S_PRE3: if (eng_done) begin
                    if (eng_rdata[3]) begin
                        code_q <= RES_LATE; eopen_q <= 1'b0; state_q <= S_RESP;
                    end else state_q <= S_CMD;
                end
                S_POST3: if (eng_done) begin
                    if (eng_rdata[3]) begin
                        code_q <= RES_LATE; eopen_q <= 1'b0; state_q <= S_RESP;
                    end else state_q <= more_q ? S_RESP : S_POLL1;
                end
                S_POLL1, S_RCHK1: if (eng_done) begin
                    r1_q    <= eng_rdata;
                    state_q <= (state_q == S_POLL1) ? S_POLL2 : S_RCHK2;
                end
                S_POLL2: if (eng_done) begin
                    if (r1_q[6] == eng_rdata[6]) state_q <= S_VERIFY;
                    else if (eng_rdata[5])       state_q <= S_RCHK1;
                    else                         state_q <= S_POLL1;
                end
                S_RCHK2: if (eng_done)
                    state_q <= (r1_q[6] == eng_rdata[6]) ? S_VERIFY : S_RESET;
                S_RESET: if (eng_done) begin
                    code_q <= RES_TIMEOUT; bypass_q <= 1'b0; eopen_q <= 1'b0;
                    state_q <= S_RESP;
                end
                S_VERIFY: if (eng_done) begin
                    eopen_q <= 1'b0;
                    code_q  <= (eng_rdata == expect_d) ? RES_OK : RES_VERIFY;
                    state_q <= S_RESP;
                end
                S_RESP: state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    fbus_cycle #(
        .AW(AW), .DW(DW), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE),
        .T_HOLD(T_HOLD), .T_RACC(T_RACC)
    ) bus_i (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .rd(eng_rd),
        .addr(eng_addr), .wdata(eng_wdata), .done(eng_done), .rdata(eng_rdata),
        .f_addr(f_addr), .f_dq_o(f_dq_o), .f_dq_oe(f_dq_oe), .f_ce_n(f_ce_n),
        .f_we_n(f_we_n), .f_oe_n(f_oe_n), .f_dq_i(f_dq_i)
    );

    // R13
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));
    // R13
    ready_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (f_ce_n && !eng_done));
    // R5
    late_only_on_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RES_LATE) |-> add_q);
    // R11
    timeout_after_reset_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RES_TIMEOUT) |-> $past(state_q == S_RESET));
endmodule

// File: tb/flash_seq_tb_top.sv
module flash_seq_tb_top;
    localparam int AW = 20, DW = 16;
    localparam int TS = 2, TP = 3, TH = 1, TR = 2;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          req_valid = 1'b0, req_more = 1'b0;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_ready, rsp_valid, f_dq_oe, f_ce_n, f_we_n, f_oe_n;
    logic [1:0]    rsp_code;
    logic [AW-1:0] f_addr;
    logic [DW-1:0] f_dq_o, f_dq_i;

    always #4 clk = ~clk;

    flash_seq #(.AW(AW), .DW(DW), .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH), .T_RACC(TR)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_more(req_more),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .f_addr(f_addr), .f_dq_o(f_dq_o),
        .f_dq_oe(f_dq_oe), .f_ce_n(f_ce_n), .f_we_n(f_we_n), .f_oe_n(f_oe_n), .f_dq_i(f_dq_i)
    );

    int vectors = 0, errors = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // flash model state and knobs
    int  exp_a[$], exp_d[$], exp_k[$];
    logic [DW-1:0] mem [16];
    int  rsel = 0, busy_len = 0, busy_knob = 0, dq5_at = -1;
    bit  corrupt = 0, status_mode = 0, dq3_cur = 0, dq3_pre = 0, dq3_post = 0;
    bit  pending = 0, rsp_seen = 0;
    int  rsp_got = 0;
    int  ce_pre = 0, we_cnt = 0, hold_cnt = 0, oe_cnt = 0, wa = 0;
    bit  after_pulse = 0, prev_we = 1, prev_oe = 1;

    always_comb begin
        if (rsel < busy_len)
            f_dq_i = DW'({rsel[0], (dq5_at >= 0 && rsel >= dq5_at), 5'b0});
        else if (status_mode)
            f_dq_i = DW'({dq3_cur, 3'b0});
        else
            f_dq_i = mem[f_addr[3:0]];
    end

    task automatic expect_w(input int a, input int d, input int k);
        exp_a.push_back(a); exp_d.push_back(d); exp_k.push_back(k);
    endtask

    // per-clock monitor and flash model
    always @(negedge clk) begin
        if (rst_n) begin
            check(req_ready == !pending, "R13 ready", req_ready, !pending);
            if (rsp_valid) begin
                check(pending, "R13 unsolicited rsp", 1, 0);
                rsp_got = rsp_code; rsp_seen = 1; pending = 0;
            end
            if (f_ce_n) begin
                if (after_pulse) check(hold_cnt == TH, "R6 hold", hold_cnt, TH);
                after_pulse = 0; ce_pre = 0;
            end else if (after_pulse && f_we_n) hold_cnt++;
            else if (f_we_n && f_oe_n && prev_we) ce_pre++;
            if (prev_we && !f_we_n) begin
                check(ce_pre == TS, "R6 setup", ce_pre, TS);
                wa = f_addr; we_cnt = 0;
            end
            if (!f_we_n) begin
                we_cnt++;
                check(f_oe_n && f_dq_oe && f_addr == wa, "R6 strobe frame", f_addr, wa);
            end
            if (!prev_we && f_we_n) begin
                check(we_cnt == TP, "R6 pulse", we_cnt, TP);
                after_pulse = 1; hold_cnt = 1;
                if (exp_a.size() == 0) check(0, "R1 unexpected write", f_dq_o, 0);
                else begin
                    int ea, ed, ek;
                    ea = exp_a.pop_front(); ed = exp_d.pop_front(); ek = exp_k.pop_front();
                    check(wa == ea, "R1 write addr", wa, ea);
                    check(f_dq_o == DW'(ed), "R1 write data", f_dq_o, ed);
                    case (ek)
                        1: begin mem[wa[3:0]] = corrupt ? DW'(ed) ^ 16'h1 : DW'(ed);
                                 rsel = 0; busy_len = busy_knob; end
                        2: begin foreach (mem[i]) mem[i] = '1; status_mode = 0;
                                 rsel = 0; busy_len = busy_knob; end
                        3: begin status_mode = 1; dq3_cur = dq3_pre; end
                        4: dq3_cur = dq3_post;
                        5: busy_len = 0;
                        default: ;
                    endcase
                end
            end
            if (!f_oe_n) begin
                oe_cnt++;
                check(f_we_n && !f_dq_oe, "R7 read frame", f_we_n, 1);
            end
            if (!prev_oe && f_oe_n) begin
                check(oe_cnt == TR, "R7 access", oe_cnt, TR);
                oe_cnt = 0; rsel++;
            end
            prev_we = f_we_n; prev_oe = f_oe_n;
        end
    end

    task automatic run(input int op, input int a, input int d, input bit more,
                       input int exp_code, input string req);
        int n = 0;
        rsp_seen = 0;
        @(negedge clk);
        req_valid = 1; req_op = 2'(op); req_addr = AW'(a); req_data = DW'(d); req_more = more;
        @(posedge clk);
        pending = 1;
        @(negedge clk);
        req_valid = 0;
        while (!rsp_seen && n < 5000) begin @(posedge clk); n++; end
        check(rsp_seen, {req, " response"}, rsp_seen, 1);
        check(rsp_got == exp_code, {req, " code"}, rsp_got, exp_code);
        check(exp_a.size() == 0, {req, " writes left"}, exp_a.size(), 0);
        exp_a.delete(); exp_d.delete(); exp_k.delete();
    endtask

    task automatic prog_writes(input int a, input int d);
        expect_w('h555, 'hAA, 0); expect_w('h2AA, 'h55, 0);
        expect_w('h555, 'hA0, 0); expect_w(a, d, 1);
    endtask

    task automatic erase_writes(input int sa, input int k);
        expect_w('h555, 'hAA, 0); expect_w('h2AA, 'h55, 0); expect_w('h555, 'h80, 0);
        expect_w('h555, 'hAA, 0); expect_w('h2AA, 'h55, 0); expect_w(sa, 'h30, k);
    endtask

    initial begin
        foreach (mem[i]) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(f_ce_n && f_we_n && f_oe_n && !f_dq_oe, "R13 reset bus idle", {f_ce_n, f_we_n, f_oe_n}, 7);
        check(req_ready && !rsp_valid, "R13 reset ready", req_ready, 1);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R1 R9: single program, one toggling pair then steady
        busy_knob = 2; dq5_at = -1; prog_writes('h5, 'h1234);
        run(0, 'h5, 'h1234, 0, 0, "R1 R9 program");
        // R8: completes on first pair
        busy_knob = 0; prog_writes('h6, 'hBEEF);
        run(0, 'h6, 'hBEEF, 0, 0, "R8 no toggle");
        // R10: bit5 rises as toggling stops
        busy_knob = 4; dq5_at = 3; prog_writes('h7, 'h0F0F);
        run(0, 'h7, 'h0F0F, 0, 0, "R10 recheck ok");
        // R11: still toggling after bit5
        busy_knob = 1000; dq5_at = 1; prog_writes('h8, 'h5555); expect_w(0, 'hF0, 5);
        run(0, 'h8, 'h5555, 0, 1, "R11 timeout");
        // R12: read-back mismatch
        busy_knob = 2; dq5_at = -1; corrupt = 1; prog_writes('h9, 'hA5A5);
        run(0, 'h9, 'hA5A5, 0, 2, "R12 verify fail");
        corrupt = 0;
        // R2: bypass entry then short words
        expect_w('h555, 'hAA, 0); expect_w('h2AA, 'h55, 0); expect_w('h555, 'h20, 0);
        expect_w(0, 'hA0, 0); expect_w('h10, 'h1111, 1);
        run(1, 'h10, 'h1111, 0, 0, "R2 bypass first");
        busy_knob = 0; expect_w(0, 'hA0, 0); expect_w('h11, 'h2222, 1);
        run(1, 'h11, 'h2222, 0, 0, "R2 bypass next");
        // R3: exit and re-entry
        expect_w(0, 'h90, 0); expect_w(0, 'h00, 0);
        run(2, 0, 0, 0, 0, "R3 bypass exit");
        expect_w('h555, 'hAA, 0); expect_w('h2AA, 'h55, 0); expect_w('h555, 'h20, 0);
        expect_w(0, 'hA0, 0); expect_w('h12, 'h3333, 1);
        run(1, 'h12, 'h3333, 0, 0, "R3 reentry");
        expect_w(0, 'h90, 0); expect_w(0, 'h00, 0);
        run(2, 0, 0, 0, 0, "R3 exit again");
        // R4 R5: three-sector erase
        dq3_pre = 0; dq3_post = 0; busy_knob = 2;
        erase_writes('h40000, 3);
        run(3, 'h40000, 0, 1, 0, "R4 erase open");
        expect_w('h50000, 'h30, 4);
        run(3, 'h50000, 0, 1, 0, "R5 add sector");
        expect_w('h60000, 'h30, 2);
        run(3, 'h60000, 0, 0, 0, "R5 R12 last sector");
        // R5: window closed before add
        dq3_pre = 1; erase_writes('h40000, 3);
        run(3, 'h40000, 0, 1, 0, "R4 erase open 2");
        run(3, 'h50000, 0, 0, 3, "R5 late pre");
        // R5: add not accepted after write
        dq3_pre = 0; dq3_post = 1; erase_writes('h40000, 3);
        run(3, 'h40000, 0, 1, 0, "R4 erase open 3");
        expect_w('h50000, 'h30, 4);
        run(3, 'h50000, 0, 0, 3, "R5 late post");

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R13 watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule